// File: doc/BRIEF.md
# Accumulator Core with One-Shot Index

This block is a compact stored-program processor built around a single accumulator. Every 16-bit memory word is either data or an instruction. An instruction carries a 3-bit operation code in its top bits and a 13-bit address field below it. The core fetches a word from a synchronous memory port, decodes it, and then either finishes at once or reads one operand word before it commits. Eight operations exist. Together they give a call through a pointer word, a store, a bit clear, a one-place right rotate, a negated load, an add, and a counted loop step that decrements and branches.

There are no addressing modes. Indirection uses a one-shot index register instead. The index operation copies the low 13 bits of a memory word into that register. The next instruction adds the register to its own address field and clears it in the same step. This lets tables, pointers and computed stores work without self-modifying code. Memory has a fixed read latency of one clock: data for an address presented with `mem_rd` at edge N is valid on `mem_rdata` during the cycle after edge N.

Top module: `acc_core`

## Requirements
- R1: While reset is low, and at the first edge after it is released, the program counter and the accumulator read zero and the index register is empty. The first fetch is from address 0.
- R2: An instruction word holds the operation code in bits [15:13] and the address field in bits [12:0]. A fetch cycle issues a read at the program counter. A decode cycle follows it. Operations that read an operand add an execute cycle, so they take three cycles. Store and loop-step take two cycles. A read and a write are never issued in the same cycle.
- R3: Code 1 writes the accumulator to the effective address during its decode cycle and leaves the accumulator unchanged.
- R4: Code 6 sets the accumulator to accumulator plus operand, modulo 2^16.
- R5: Code 3 sets the accumulator to accumulator AND NOT operand.
- R6: Code 4 loads the operand rotated right by one place, so bit 0 moves to bit 15.
- R7: Code 5 loads the two's complement of the operand.
- R8: Code 7 decrements the accumulator. It jumps to the effective address if the result is nonzero, and otherwise continues with the next word. A zero accumulator wraps to all ones, which is nonzero, so it jumps.
- R9: Code 0 reads the pointer word at the effective address. Its low 13 bits, T, are the target. The core writes the return address (call address + 1, zero-extended) into word T and continues at T + 1.
- R10: Code 2 loads the low 13 bits of the addressed word into the index register. The next instruction adds this value to its address field, modulo 2^13, and the register is then zero. An index instruction that follows another index instruction consumes the old value for its own address and loads a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 13 | Word address for the read or the write |
| mem_rd | output | 1 | Read request; data returns on the following cycle |
| mem_wr | output | 1 | Write request, committed at the clock edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| acc_o | output | 16 | Current accumulator |
| pc_o | output | 13 | Current program counter |

## Verification
The decode cycle does two jobs at once. It consumes the index register and it uses the resulting effective address for a store write or a loop-step branch target. A stale or early clear would redirect that same access. The bench provokes this case with an index followed by a store, an index followed by another index, and an index followed by a negated load whose address field sits just below the top of the address space, so the sum must wrap. It judges each case by which memory word receives the data and which one stays untouched.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_CALL    = 3'd0,
    OP_STORE   = 3'd1,
    OP_INDEX   = 3'd2,
    OP_CLRBITS = 3'd3,
    OP_ROTR    = 3'd4,
    OP_NEGLD   = 3'd5,
    OP_ADD     = 3'd6,
    OP_DECJNZ  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_DEC   = 2'd1,
    ST_EXEC  = 2'd2
  } st_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res
);
  function automatic logic [DW-1:0] f_rotr(input logic [DW-1:0] v);
    return {v[0], v[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] f_neg(input logic [DW-1:0] v);
    return (~v) + 1'b1;
  endfunction

  function automatic logic [DW-1:0] f_clrbits(input logic [DW-1:0] a, input logic [DW-1:0] m);
    return a & ~m;
  endfunction

  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] m);
    return a + m;
  endfunction

  function automatic logic [DW-1:0] f_dec(input logic [DW-1:0] a);
    return a - 1'b1;
  endfunction

  always_comb begin
    case (op)
      OP_ADD:     res = f_add(acc, opnd);
      OP_CLRBITS: res = f_clrbits(acc, opnd);
      OP_ROTR:    res = f_rotr(opnd);
      OP_NEGLD:   res = f_neg(opnd);
      OP_DECJNZ:  res = f_dec(acc);
      default:    res = acc;
    endcase
  end
endmodule

// File: rtl/acc_idx.sv
module acc_idx #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          consume,
  output logic [AW-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (load)    idx_q <= load_val;
    else if (consume) idx_q <= '0;
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW - OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] idx_val,
  input  logic [DW-1:0] alu_res,
  output op_e           alu_op,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] acc_q,
  output logic [AW-1:0] pc_q,
  output logic          idx_load,
  output logic          idx_consume,
  output logic          st_fetch,
  output logic          jump_taken,
  output logic [AW-1:0] jump_tgt,
  output logic          call_write
);
  st_e           state_q;
  op_e           op_q;
  op_e           opd;
  logic [AW-1:0] ea_dec;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] call_tgt;

  assign opd      = op_e'(mem_rdata[DW-1:AW]);
  assign ea_dec   = mem_rdata[AW-1:0] + idx_val;
  assign pc_inc   = pc_q + 1'b1;
  assign call_tgt = mem_rdata[AW-1:0];
  assign alu_op   = (state_q == ST_DEC) ? opd : op_q;

  assign st_fetch    = (state_q == ST_FETCH);
  assign idx_consume = (state_q == ST_DEC);
  assign idx_load    = (state_q == ST_EXEC) && (op_q == OP_INDEX);
  assign call_write  = (state_q == ST_EXEC) && (op_q == OP_CALL);
  assign jump_taken  = (state_q == ST_DEC) && (opd == OP_DECJNZ) && (alu_res != '0);
  assign jump_tgt    = ea_dec;

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = acc_q;
    case (state_q)
      ST_FETCH: mem_rd = 1'b1;
      ST_DEC: begin
        if (opd == OP_STORE) begin
          mem_wr   = 1'b1;
          mem_addr = ea_dec;
        end else if (opd != OP_DECJNZ) begin
          mem_rd   = 1'b1;
          mem_addr = ea_dec;
        end
      end
      ST_EXEC: begin
        if (op_q == OP_CALL) begin
          mem_wr    = 1'b1;
          mem_addr  = call_tgt;
          mem_wdata = {{OPW{1'b0}}, pc_inc};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      op_q    <= OP_CALL;
      acc_q   <= '0;
      pc_q    <= '0;
    end else begin
      case (state_q)
        ST_FETCH: state_q <= ST_DEC;
        ST_DEC: begin
          op_q <= opd;
          case (opd)
            OP_STORE: begin
              pc_q    <= pc_inc;
              state_q <= ST_FETCH;
            end
            OP_DECJNZ: begin
              acc_q   <= alu_res;
              pc_q    <= (alu_res != '0) ? ea_dec : pc_inc;
              state_q <= ST_FETCH;
            end
            default: state_q <= ST_EXEC;
          endcase
        end
        ST_EXEC: begin
          case (op_q)
            OP_CALL:  pc_q <= call_tgt + 1'b1;
            OP_INDEX: pc_q <= pc_inc;
            default: begin
              acc_q <= alu_res;
              pc_q  <= pc_inc;
            end
          endcase
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW - OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o
);
  op_e           alu_op;
  logic [DW-1:0] alu_res;
  logic [AW-1:0] idx_q;
  logic          idx_load;
  logic          idx_consume;
  logic          st_fetch;
  logic          jump_taken;
  logic [AW-1:0] jump_tgt;
  logic          call_write;

  acc_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rdata   (mem_rdata),
    .idx_val     (idx_q),
    .alu_res     (alu_res),
    .alu_op      (alu_op),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .acc_q       (acc_o),
    .pc_q        (pc_o),
    .idx_load    (idx_load),
    .idx_consume (idx_consume),
    .st_fetch    (st_fetch),
    .jump_taken  (jump_taken),
    .jump_tgt    (jump_tgt),
    .call_write  (call_write)
  );

  acc_alu #(.DW(DW)) u_alu (
    .op   (alu_op),
    .acc  (acc_o),
    .opnd (mem_rdata),
    .res  (alu_res)
  );

  acc_idx #(.AW(AW)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idx_load),
    .load_val (mem_rdata[AW-1:0]),
    .consume  (idx_consume),
    .idx_q    (idx_q)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 16,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] acc_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] idx_q,
  input logic          idx_consume,
  input logic          st_fetch,
  input logic          jump_taken,
  input logic [AW-1:0] jump_tgt,
  input logic          call_write
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> (pc_o == '0 && acc_o == '0 && idx_q == '0));

  // R2
  fetch_at_pc_chk: assert property (@(posedge clk) disable iff (!rst_n) st_fetch |-> (mem_rd && mem_addr == pc_o));

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));

  // R3
  write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> $stable(acc_o));

  // R8
  loop_jump_chk: assert property (@(posedge clk) disable iff (!rst_n) jump_taken |=> pc_o == $past(jump_tgt));

  // R9
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n) call_write |-> mem_wdata[AW-1:0] == AW'(pc_o + 1'b1));

  // R9
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n) call_write |=> pc_o == AW'($past(mem_addr) + 1'b1));

  // R10
  index_once_chk: assert property (@(posedge clk) disable iff (!rst_n) idx_consume |=> idx_q == '0);
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_wdata   (mem_wdata),
  .acc_o       (acc_o),
  .pc_o        (pc_o),
  .idx_q       (idx_q),
  .idx_consume (idx_consume),
  .st_fetch    (st_fetch),
  .jump_taken  (jump_taken),
  .jump_tgt    (jump_tgt),
  .call_write  (call_write)
);

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] acc_o;
  logic [12:0] pc_o;

  logic [15:0] mem [0:255];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int first_wr = -1;
  int oob = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_o(acc_o), .pc_o(pc_o)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (rst_n && (mem_rd || mem_wr) && mem_addr >= 13'd256) oob <= oob + 1;
    if (!rst_n) begin
      cyc <= 0;
      first_wr <= -1;
    end else begin
      cyc <= cyc + 1;
      if (mem_wr && first_wr < 0) first_wr <= cyc;
    end
  end

  function automatic logic [15:0] ins(input int op, input int a);
    logic [15:0] w;
    w = {op[2:0], a[12:0]};
    return w;
  endfunction

  function automatic logic [15:0] neg(input logic [15:0] v);
    return 16'd0 - v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic go(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] dval(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h8000;
      3: return 16'hFFFF;
      default: return 16'((i * 40507) ^ (i << 9) ^ 16'h5C3A);
    endcase
  endfunction

  initial begin
    logic [15:0] a, d, e;
    // R1: reset state and first fetch
    hold_reset();
    chk(pc_o == 13'd0, "R1 pc", {3'd0, pc_o}, 16'd0);
    chk(acc_o == 16'd0, "R1 acc", acc_o, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    chk(mem_rd && mem_addr == 13'd0, "R1 first fetch", {3'd0, mem_addr}, 16'd0);

    // R4 R5 R6 R7: operand sweep with a loaded accumulator
    for (int op = 3; op <= 6; op++) begin
      for (int i = 0; i < 12; i++) begin
        a = dval(i + 5);
        d = dval(i);
        hold_reset();
        mem[0] = ins(5, 100); mem[1] = ins(op, 101); mem[2] = ins(1, 102); mem[3] = ins(0, 103);
        mem[100] = neg(a); mem[101] = d; mem[103] = 16'd2;
        go(30);
        case (op)
          3: e = a & ~d;
          4: e = {d[0], d[15:1]};
          5: e = neg(d);
          default: e = a + d;
        endcase
        chk(acc_o == e, (op == 3) ? "R5 clear bits" : (op == 4) ? "R6 rotate" : (op == 5) ? "R7 negate" : "R4 add", acc_o, e);
        chk(mem[102] == e, "R3 store value", mem[102], e);
        if (op == 6 && i == 0) chk(first_wr == 7, "R2 cycle count to first store", 16'(first_wr), 16'd7);
      end
    end

    // R1: reset clears a nonzero accumulator
    hold_reset();
    chk(acc_o == 16'd0 && pc_o == 13'd0, "R1 reset after run", acc_o, 16'd0);

    // R8: loop step, both outcomes
    for (int i = 0; i < 10; i++) begin
      a = (i < 4) ? dval(i) : ((i == 4) ? 16'd2 : dval(i + 20));
      hold_reset();
      mem[0] = ins(5, 100); mem[1] = ins(7, 5); mem[2] = ins(1, 110); mem[3] = ins(0, 103);
      mem[5] = ins(1, 111); mem[6] = ins(0, 104);
      mem[100] = neg(a); mem[103] = 16'd2; mem[104] = 16'd5;
      mem[110] = 16'hDEAD; mem[111] = 16'hDEAD;
      go(30);
      e = a - 16'd1;
      chk(acc_o == e, "R8 decrement", acc_o, e);
      if (e == 16'd0) begin
        chk(mem[110] == 16'd0, "R8 fall through store", mem[110], 16'd0);
        chk(mem[111] == 16'hDEAD, "R8 no jump", mem[111], 16'hDEAD);
      end else begin
        chk(mem[111] == e, "R8 jump store", mem[111], e);
        chk(mem[110] == 16'hDEAD, "R8 no fall through", mem[110], 16'hDEAD);
      end
    end

    // R9: call through pointer word
    for (int t = 40; t <= 80; t += 20) begin
      hold_reset();
      mem[0] = ins(0, 103); mem[103] = 16'(t);
      mem[t + 1] = ins(5, 100); mem[t + 2] = ins(1, 102); mem[t + 3] = ins(0, 104);
      mem[104] = 16'(t + 2); mem[100] = neg(16'h0C0F + 16'(t));
      go(40);
      chk(mem[t] == 16'd1, "R9 return link", mem[t], 16'd1);
      chk(mem[102] == 16'h0C0F + 16'(t), "R9 continue at target+1", mem[102], 16'h0C0F + 16'(t));
    end

    // R10: index applied once, sweep of offsets
    for (int k = 0; k < 8; k++) begin
      hold_reset();
      mem[0] = ins(2, 120); mem[1] = ins(5, 130); mem[2] = ins(1, 102);
      mem[3] = ins(5, 140); mem[4] = ins(1, 105); mem[5] = ins(0, 103);
      mem[120] = 16'(k); mem[130 + k] = neg(16'(k * 273 + 5)); mem[140] = neg(16'h0077);
      mem[103] = 16'd4;
      go(40);
      chk(mem[102] == 16'(k * 273 + 5), "R10 indexed load", mem[102], 16'(k * 273 + 5));
      chk(mem[105] == 16'h0077, "R10 index cleared", mem[105], 16'h0077);
    end

    // R10: address sum wraps
    hold_reset();
    mem[0] = ins(2, 120); mem[1] = ins(5, 13'h1FF0); mem[2] = ins(1, 102); mem[3] = ins(0, 103);
    mem[120] = 16'h0020; mem[16] = neg(16'h1234); mem[103] = 16'd2;
    go(40);
    chk(mem[102] == 16'h1234, "R10 wrap", mem[102], 16'h1234);
    chk(oob == 0, "R10 wrap address in range", 16'(oob), 16'd0);

    // R10: index after index
    hold_reset();
    mem[0] = ins(2, 120); mem[1] = ins(2, 150); mem[2] = ins(5, 130); mem[3] = ins(1, 102);
    mem[4] = ins(0, 103);
    mem[120] = 16'd3; mem[153] = 16'd4; mem[150] = 16'd1; mem[134] = neg(16'h0ABC);
    mem[103] = 16'd3;
    go(40);
    chk(mem[102] == 16'h0ABC, "R10 chained index", mem[102], 16'h0ABC);

    // R3 R10: indexed store
    hold_reset();
    mem[0] = ins(5, 100); mem[1] = ins(2, 120); mem[2] = ins(1, 160); mem[3] = ins(0, 103);
    mem[100] = neg(16'h5A5A); mem[120] = 16'd6; mem[103] = 16'd2;
    go(40);
    chk(mem[166] == 16'h5A5A, "R3 indexed store target", mem[166], 16'h5A5A);
    chk(mem[160] == 16'h0000, "R3 unindexed word untouched", mem[160], 16'h0000);
    chk(acc_o == 16'h5A5A, "R3 acc kept", acc_o, 16'h5A5A);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule